// File: doc/BRIEF.md
# 32-bit SEC-DED Memory Error Checker and Corrector

This block guards 32-bit memory words with a 7-bit check code. On the way into memory it computes the check code for the outgoing word. On the way back it compares the 39-bit word read from memory against a freshly computed code and raises two active-low flags. In correction mode it repairs any single flipped data bit and presents the syndrome on the check port, so a failing position can be located.

A 2-bit mode input selects the operation. The block holds the last memory word in input latches, so correction and diagnostics can work from stored values while the data port carries something else. A hold input freezes the data output latch. Together with per-byte output disables, this lets a controller merge new bytes into a corrected word before it is written back. The pads are not modelled: each bidirectional port is split into an input, an output and an output enable.

Top module: `mem_edac32`

## Requirements
- R1: Mode select: 2'b00 write, 2'b01 diagnose, 2'b10 read-check, 2'b11 correct. The data input latch loads `data_in` on every clock except in correct mode. The check input latch loads `check_in` only in read-check mode.
- R2: In write mode `check_out` is the check code of `data_in`. Check bit r is the XOR of the data bits whose column code has bit r set, then XORed with 7'h09 (bits 0 and 3 inverted). The 32 column codes are, from data bit 0 upward: 7,13,14,19,25,26,28,31,35,37,38,41,42,52,56,62,67,70,73,76,79,81,82,84,97,100,103,112,115,121,122,124. Each check bit covers 16 data bits. Data 0 gives 7'h09 and data 1 gives 7'h0E.
- R3: In correct mode, a single flipped data bit in the latched word raises `err_n` low, keeps `merr_n` high, and on the next clock the corrected word appears on `data_out`.
- R4: The syndrome is the received check code XOR the code computed from the data. A single flipped check bit gives a one-hot syndrome on that bit, lowers `err_n` only, and the data passes through unchanged. In correct mode `check_out` carries the syndrome.
- R5: In write mode `err_n` and `merr_n` are both high.
- R6: Any two flipped bits among the 39 (two data, two check, or one of each) lower both flags, and the data is not altered. `merr_n` low always comes with `err_n` low.
- R7: A memory word of all zeros or all ones lowers both flags.
- R8: `data_oe[i]` (bits 8i..8i+7) is high only in correct mode while `byte_dis[i]` is low. `check_oe` is high in write or correct mode while `chk_dis` is low.
- R9: While `dlatch_hold` is high, `data_out` does not change.
- R10: In diagnose mode the latched check code is held, and the flags judge `data_in` against it.
- R11: Reset (`rst_n` low) clears all latches, so `data_out` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | Operation select |
| data_in | input | 32 | Data word from bus or memory |
| data_out | output | 32 | Data output latch |
| data_oe | output | 4 | Per-byte data drive enables |
| byte_dis | input | 4 | Per-byte output disable, active high |
| dlatch_hold | input | 1 | Freezes the data output latch when high |
| check_in | input | 7 | Check code read from memory |
| check_out | output | 7 | Generated check code or syndrome |
| check_oe | output | 1 | Check port drive enable |
| chk_dis | input | 1 | Check port output disable, active high |
| err_n | output | 1 | Low when at least one error is seen |
| merr_n | output | 1 | Low when the error cannot be corrected |

## Verification
The assertions assume that `mode` changes only between clock edges and that reset is released away from an edge. They also assume the hold input is sampled on the same edge as the mode, so a hold cycle and a correct cycle are judged together. The stimulus drives every input just after a falling edge, always fills the input latches in read-check mode before entering correct or diagnose mode, and flips at most two of the 39 bits except for the deliberate all-zero and all-one words.

// File: rtl/mem_edac_pkg.sv
package mem_edac_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned CHK_W  = 7;
    localparam int unsigned CODE_N = 1 << CHK_W;

    // check bits 0 and 3 carry inverted parity
    localparam logic [CHK_W-1:0] CHK_INV = 7'h09;

    typedef enum logic [1:0] {
        MODE_WRITE   = 2'b00,
        MODE_DIAG    = 2'b01,
        MODE_READ    = 2'b10,
        MODE_CORRECT = 2'b11
    } edac_mode_e;

    typedef logic [DATA_W-1:0][CHK_W-1:0] col_table_t;

    // weight-3 codes left out of the matrix to balance row weights
    function automatic logic is_dropped_triple(input logic [CHK_W-1:0] v);
        logic r;
        case (v)
            7'd11, 7'd21, 7'd22, 7'd44, 7'd49, 7'd50,
            7'd69, 7'd74, 7'd88, 7'd98, 7'd104: r = 1'b1;
            default: r = 1'b0;
        endcase
        return r;
    endfunction

    // weight-2 codes whose complements become weight-5 columns
    function automatic logic is_kept_pair(input logic [CHK_W-1:0] v);
        logic r;
        case (v)
            7'd3, 7'd5, 7'd6, 7'd12, 7'd24, 7'd48, 7'd65, 7'd96: r = 1'b1;
            default: r = 1'b0;
        endcase
        return r;
    endfunction

    function automatic logic is_column(input logic [CHK_W-1:0] v);
        int w;
        w = $countones(v);
        if (w == 3) return !is_dropped_triple(v);
        if (w == 5) return is_kept_pair(~v);
        return 1'b0;
    endfunction

    // columns in ascending code order, data bit 0 first
    function automatic col_table_t build_cols();
        col_table_t t;
        int n;
        t = '0;
        n = 0;
        for (int v = 1; v < CODE_N; v++) begin
            if (n < DATA_W && is_column(CHK_W'(v))) begin
                t[n] = CHK_W'(v);
                n++;
            end
        end
        return t;
    endfunction

    localparam col_table_t H_COLS = build_cols();

endpackage

// File: rtl/edac_parity_gen.sv
module edac_parity_gen
    import mem_edac_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    output logic [CHK_W-1:0]  code_o
);
    logic [CHK_W-1:0] par;

    generate
        for (genvar r = 0; r < CHK_W; r++) begin : g_row
            always_comb begin
                par[r] = 1'b0;
                for (int c = 0; c < DATA_W; c++) begin
                    par[r] = par[r] ^ (data_i[c] & H_COLS[c][r]);
                end
            end
        end
    endgenerate

    assign code_o = par ^ CHK_INV;

endmodule

// File: rtl/edac_syn_decode.sv
module edac_syn_decode
    import mem_edac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              check_en,
    input  logic [CHK_W-1:0]  syn_i,
    output logic [DATA_W-1:0] flip_o,
    output logic              err_n,
    output logic              merr_n
);
    logic any_err;
    logic data_single;
    logic chk_single;
    logic multi;

    generate
        for (genvar c = 0; c < DATA_W; c++) begin : g_col
            assign flip_o[c] = (syn_i == H_COLS[c]);
        end
    endgenerate

    always_comb begin
        any_err     = |syn_i;
        data_single = |flip_o;
        chk_single  = $onehot(syn_i);
        multi       = any_err && !(data_single || chk_single);
        err_n       = !(check_en && any_err);
        merr_n      = !(check_en && multi);
    end

    // R6: an uncorrectable report always comes with the error flag
    p_merr_has_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !merr_n |-> !err_n);

    // R3: at most one data position is ever repaired
    p_single_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flip_o));

    // R4: a clean syndrome never raises a flag
    p_clean_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (syn_i == '0) |-> (err_n && merr_n));

endmodule

// File: rtl/mem_edac32.sv
module mem_edac32
    import mem_edac_pkg::*;
#(
    parameter int unsigned LANE_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [1:0]                mode,
    input  logic [DATA_W-1:0]         data_in,
    output logic [DATA_W-1:0]         data_out,
    output logic [DATA_W/LANE_W-1:0]  data_oe,
    input  logic [DATA_W/LANE_W-1:0]  byte_dis,
    input  logic                      dlatch_hold,
    input  logic [CHK_W-1:0]          check_in,
    output logic [CHK_W-1:0]          check_out,
    output logic                      check_oe,
    input  logic                      chk_dis,
    output logic                      err_n,
    output logic                      merr_n
);
    localparam int unsigned LANES = DATA_W / LANE_W;

    typedef struct packed {
        logic [DATA_W-1:0] in_data;
        logic [CHK_W-1:0]  in_chk;
        logic [DATA_W-1:0] out_data;
    } edac_state_t;

    edac_state_t st_d, st_q;

    edac_mode_e        md;
    logic [DATA_W-1:0] work_data;
    logic [CHK_W-1:0]  recv_chk;
    logic [CHK_W-1:0]  calc_chk;
    logic [CHK_W-1:0]  syn;
    logic [DATA_W-1:0] flip;
    logic [DATA_W-1:0] corr_word;
    logic              chk_en;

    assign md = edac_mode_e'(mode);

    edac_parity_gen u_gen (
        .data_i (work_data),
        .code_o (calc_chk)
    );

    edac_syn_decode u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .check_en (chk_en),
        .syn_i    (syn),
        .flip_o   (flip),
        .err_n    (err_n),
        .merr_n   (merr_n)
    );

    always_comb begin
        // select the word under test
        case (md)
            MODE_READ:    begin work_data = data_in;     recv_chk = check_in;     end
            MODE_DIAG:    begin work_data = data_in;     recv_chk = st_q.in_chk;  end
            MODE_CORRECT: begin work_data = st_q.in_data; recv_chk = st_q.in_chk; end
            default:      begin work_data = data_in;     recv_chk = calc_chk;     end
        endcase
        chk_en    = (md != MODE_WRITE);
        syn       = recv_chk ^ calc_chk;
        corr_word = work_data ^ flip;
        check_out = (md == MODE_CORRECT) ? syn : calc_chk;
        check_oe  = !chk_dis && (md == MODE_WRITE || md == MODE_CORRECT);
        data_oe   = {LANES{md == MODE_CORRECT}} & ~byte_dis;

        // next-state values
        st_d = st_q;
        if (md != MODE_CORRECT) st_d.in_data = data_in;
        if (md == MODE_READ)    st_d.in_chk  = check_in;
        if (md == MODE_CORRECT && !dlatch_hold) st_d.out_data = corr_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_out = st_q.out_data;

    // R9: a held output latch keeps its word
    p_hold_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dlatch_hold |=> $stable(data_out));

    // R8: data lanes are only driven while correcting
    p_lane_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|data_oe) |-> (mode == MODE_CORRECT));

    // R5: no flags while generating check codes
    p_write_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_WRITE) |-> (err_n && merr_n));

    // R10: diagnosis never disturbs the held check code
    p_diag_keeps_chk_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_DIAG) |=> $stable(st_q.in_chk));

    // R3: correction differs from the latched word in at most one bit
    p_one_bit_fix_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_CORRECT) |-> $onehot0(corr_word ^ st_q.in_data));

endmodule

// File: tb/mem_edac32_tb_top.sv
module mem_edac32_tb_top;

    localparam int CLK_PERIOD = 10;

    localparam logic [6:0] COLS [32] = '{
        7'd7,   7'd13,  7'd14,  7'd19,  7'd25,  7'd26,  7'd28,  7'd31,
        7'd35,  7'd37,  7'd38,  7'd41,  7'd42,  7'd52,  7'd56,  7'd62,
        7'd67,  7'd70,  7'd73,  7'd76,  7'd79,  7'd81,  7'd82,  7'd84,
        7'd97,  7'd100, 7'd103, 7'd112, 7'd115, 7'd121, 7'd122, 7'd124
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic [31:0] data_in = '0;
    logic [31:0] data_out;
    logic [3:0]  data_oe;
    logic [3:0]  byte_dis = '0;
    logic        dlatch_hold = 1'b0;
    logic [6:0]  check_in = '0;
    logic [6:0]  check_out;
    logic        check_oe;
    logic        chk_dis = 1'b0;
    logic        err_n;
    logic        merr_n;

    int checks = 0;
    int errors = 0;
    string cur_req = "R11";

    // reference state
    logic [31:0] m_in_data = '0;
    logic [6:0]  m_in_chk  = '0;
    logic [31:0] m_out     = '0;

    mem_edac32 dut_i (
        .clk (clk), .rst_n (rst_n), .mode (mode),
        .data_in (data_in), .data_out (data_out), .data_oe (data_oe),
        .byte_dis (byte_dis), .dlatch_hold (dlatch_hold),
        .check_in (check_in), .check_out (check_out), .check_oe (check_oe),
        .chk_dis (chk_dis), .err_n (err_n), .merr_n (merr_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [6:0] ref_code(input logic [31:0] d);
        logic [6:0] g = 7'h09;
        for (int c = 0; c < 32; c++) if (d[c]) g = g ^ COLS[c];
        return g;
    endfunction

    function automatic int ref_pos(input logic [6:0] s);
        int p = -1;
        for (int c = 0; c < 32; c++) if (COLS[c] == s) p = c;
        return p;
    endfunction

    function automatic logic [31:0] ref_fix(input logic [31:0] d, input logic [6:0] s);
        int p = ref_pos(s);
        logic [31:0] r = d;
        if (p >= 0) r[p] = ~r[p];
        return r;
    endfunction

    function automatic logic [31:0] ref_word();
        return (mode == 2'b11) ? m_in_data : data_in;
    endfunction

    function automatic logic [6:0] ref_recv();
        case (mode)
            2'b10:   return check_in;
            2'b01:   return m_in_chk;
            2'b11:   return m_in_chk;
            default: return ref_code(data_in);
        endcase
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        logic [6:0] syn;
        logic       single, multi;
        logic       e_err, e_merr;
        syn    = ref_recv() ^ ref_code(ref_word());
        single = (syn != 0) && (($countones(syn) == 1) || (ref_pos(syn) >= 0));
        multi  = (syn != 0) && !single;
        e_err  = (mode == 2'b00) ? 1'b1 : (syn == 0);
        e_merr = (mode == 2'b00) ? 1'b1 : !multi;
        chk(cur_req, "data_out", data_out, m_out);
        chk(cur_req, "data_oe", {28'b0, data_oe}, {28'b0, {4{mode == 2'b11}} & ~byte_dis});
        chk(cur_req, "check_oe", {31'b0, check_oe},
            {31'b0, !chk_dis && (mode == 2'b00 || mode == 2'b11)});
        chk(cur_req, "err_n", {31'b0, err_n}, {31'b0, e_err});
        chk(cur_req, "merr_n", {31'b0, merr_n}, {31'b0, e_merr});
        if (!chk_dis && (mode == 2'b00 || mode == 2'b11))
            chk(cur_req, "check_out", {25'b0, check_out},
                {25'b0, (mode == 2'b11) ? syn : ref_code(data_in)});
    endtask

    // one clock: update the model at the rising edge, compare at the falling edge
    task automatic cyc();
        logic [6:0] syn;
        @(posedge clk);
        if (rst_n) begin
            if (mode == 2'b11 && !dlatch_hold) begin
                syn   = m_in_chk ^ ref_code(m_in_data);
                m_out = ref_fix(m_in_data, syn);
            end
            if (mode != 2'b11) m_in_data = data_in;
            if (mode == 2'b10) m_in_chk  = check_in;
        end
        @(negedge clk);
        compare_all();
    endtask

    task automatic read_then_fix(input logic [31:0] d, input logic [6:0] c);
        mode = 2'b10; data_in = d; check_in = c;
        cyc();
        mode = 2'b11; data_in = 32'h0;
        cyc();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        // R11: reset state
        repeat (2) @(negedge clk);
        compare_all();
        chk("R11", "data_out at reset", data_out, 32'h0);
        rst_n = 1'b1;

        // R2, R5: write mode codes
        cur_req = "R2";
        mode = 2'b00; data_in = 32'h0; cyc();
        chk("R2", "code of 0", {25'b0, check_out}, 32'h09);
        chk("R5", "flags in write", {30'b0, err_n, merr_n}, 32'h3);
        data_in = 32'h1; cyc();
        chk("R2", "code of 1", {25'b0, check_out}, 32'h0E);
        foreach (COLS[k]) begin
            data_in = 32'h9E37_79B9 * (k + 1); cyc();
        end
        data_in = 32'hFFFF_FFFF; cyc();
        chk("R2", "code of ones", {25'b0, check_out}, 32'h09);
        cur_req = "R8"; chk_dis = 1'b1; cyc();
        chk("R8", "check_oe disabled", {31'b0, check_oe}, 32'h0);
        chk_dis = 1'b0;

        // R3: single data-bit errors, every position
        cur_req = "R3";
        d = 32'hC3A5_5A3C;
        for (int k = 0; k < 32; k++) begin
            read_then_fix(d ^ (32'h1 << k), ref_code(d));
            chk("R3", "corrected word", data_out, d);
            chk("R3", "flags single", {30'b0, err_n, merr_n}, 32'h1);
        end

        // R4: single check-bit errors
        cur_req = "R4";
        d = 32'h1234_5678;
        for (int j = 0; j < 7; j++) begin
            read_then_fix(d, ref_code(d) ^ (7'h1 << j));
            chk("R4", "syndrome", {25'b0, check_out}, 32'h1 << j);
            chk("R4", "data passes", data_out, d);
            chk("R4", "flags", {30'b0, err_n, merr_n}, 32'h1);
        end

        // R6: double errors of every kind
        cur_req = "R6";
        d = 32'h0F0F_00FF;
        read_then_fix(d ^ 32'h0000_0011, ref_code(d));
        chk("R6", "two data bits", {30'b0, err_n, merr_n}, 32'h0);
        chk("R6", "not corrected", data_out, d ^ 32'h0000_0011);
        read_then_fix(d, ref_code(d) ^ 7'h22);
        chk("R6", "two check bits", {30'b0, err_n, merr_n}, 32'h0);
        read_then_fix(d ^ 32'h8000_0000, ref_code(d) ^ 7'h01);
        chk("R6", "one of each", {30'b0, err_n, merr_n}, 32'h0);
        for (int a = 0; a < 31; a += 5) begin
            read_then_fix(d ^ (32'h1 << a) ^ (32'h1 << (a + 1)), ref_code(d));
        end

        // R7: all-zero and all-one memory words
        cur_req = "R7";
        mode = 2'b10; data_in = 32'h0; check_in = 7'h00; cyc();
        chk("R7", "all zeros", {30'b0, err_n, merr_n}, 32'h0);
        data_in = 32'hFFFF_FFFF; check_in = 7'h7F; cyc();
        chk("R7", "all ones", {30'b0, err_n, merr_n}, 32'h0);

        // R9: hold freezes the output latch
        cur_req = "R9";
        d = 32'hAAAA_5555;
        read_then_fix(d, ref_code(d));
        mode = 2'b10; data_in = 32'h1357_9BDF; check_in = ref_code(32'h1357_9BDF); cyc();
        mode = 2'b11; dlatch_hold = 1'b1; cyc(); cyc();
        chk("R9", "held word", data_out, d);
        dlatch_hold = 1'b0; cyc();
        chk("R9", "released word", data_out, 32'h1357_9BDF);

        // R8: byte disables
        cur_req = "R8";
        for (int b = 0; b < 16; b++) begin
            byte_dis = 4'(b); cyc();
            chk("R8", "lane enables", {28'b0, data_oe}, {28'b0, ~4'(b)});
        end
        byte_dis = 4'h0;

        // R10, R1: diagnose against the held check code
        cur_req = "R10";
        d = 32'h6B8D_1F20;
        mode = 2'b10; data_in = d; check_in = ref_code(d); cyc();
        mode = 2'b01; data_in = d; check_in = 7'h55; cyc();
        chk("R10", "clean diag", {30'b0, err_n, merr_n}, 32'h3);
        data_in = d ^ 32'h0000_0020; cyc();
        chk("R10", "diag single", {30'b0, err_n, merr_n}, 32'h1);
        data_in = d ^ 32'h0000_0060; cyc();
        chk("R10", "diag double", {30'b0, err_n, merr_n}, 32'h0);
        cur_req = "R1";
        data_in = d ^ 32'h0100_0000; cyc();
        mode = 2'b11; cyc(); cyc();
        chk("R1", "diag word corrected", data_out, d);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule